// File: doc/BRIEF.md
# Console Manual Storage Access Controller

This block is the sequencer behind a maintenance panel that lets an operator inspect and modify memory by hand. A two-bit mode selector picks one of three actions: loading the storage address register (SAR) from the switch bank, depositing a byte into memory, or examining a memory byte. A single start key drives every action. Pressing the key does the first half of the job, and releasing it does the second half. The block drives four visible registers: SAR, the A register (the byte being deposited), the B register (the byte just read) and the Q register (the byte last committed to memory).

Memory is reached through separate read and write strobes. A strobe stays high, with a steady address, until the memory returns a one-cycle done pulse. A storage-test switch picks the exercise style. In step mode each key press makes exactly one access. In run mode a key press starts continuous accesses, either to one fixed address or sweeping through the whole address space with wrap-around. Run mode ends when the key is pressed again or when the mode selector is moved. The start key is synchronized and edge-detected inside the block.

Top module: `console_mem_access`

## Requirements
- R1: While reset is high, SAR, A, B and Q clear to zero at the next clock and neither memory strobe is asserted.
- R2: With mode_sel = 2'b00, a key press loads SAR from sw[ADDR_W-1:0] and A from sw[DATA_W-1:0]. While the key stays down, A keeps following sw[DATA_W-1:0] and SAR holds. Releasing the key makes no memory access.
- R3: With mode_sel = 2'b01 in step mode, a key press loads A from sw[DATA_W-1:0] and makes no access. The key release writes A to memory at SAR, and Q takes A when that write completes. Q changes only on a completed write.
- R4: With mode_sel = 2'b10 in step mode, a key press reads memory at SAR into B. The key release writes B back to the same address, and Q takes B when that write completes.
- R5: In step mode, when addr_inc is 1 at the completion of the write, SAR advances by one. When addr_inc is 0, SAR keeps its value.
- R6: In step mode, one press and release makes exactly one write in mode 2'b01, and exactly one read followed by one write in mode 2'b10.
- R7: With test_run = 1 and sweep_all = 0, one press in mode 2'b01 or 2'b10 starts repeated accesses to the same address. SAR stays constant whatever addr_inc is.
- R8: With test_run = 1 and sweep_all = 1, SAR advances by one after every completed write and wraps from its all-ones value to zero.
- R9: Run mode stops when the key is pressed again or when mode_sel differs from the mode captured at the start. The access in progress completes, and no further access follows.
- R10: A key press made while a memory access is in progress is ignored: A, B and SAR are not reloaded and no extra access follows.
- R11: A press with mode_sel = 2'b11 has no effect on SAR, A, B or Q and makes no memory access.
- R12: A memory strobe stays asserted, with SAR held, until mem_done. Read and write are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | 00 load address, 01 deposit, 10 examine, 11 no action |
| sw | input | SW_W | Address/data switch bank |
| start_key | input | 1 | Debounced start key level, asynchronous |
| test_run | input | 1 | 0 step, 1 run |
| sweep_all | input | 1 | In run mode: 0 same address, 1 sequential sweep |
| addr_inc | input | 1 | Step-mode address increment enable |
| mem_rd | output | 1 | Read strobe, held until done |
| mem_wr | output | 1 | Write strobe, held until done |
| mem_addr | output | ADDR_W | Memory address (SAR) |
| mem_wdata | output | DATA_W | Write data (A or B) |
| mem_rdata | input | DATA_W | Read data, valid with mem_done |
| mem_done | input | 1 | One-cycle access completion |
| sar_o | output | ADDR_W | SAR contents |
| a_o | output | DATA_W | A register contents |
| b_o | output | DATA_W | B register contents |
| q_o | output | DATA_W | Q register contents |

## Verification
A sequencer stuck in a wrong state shows up as a strobe that never drops or never rises. It can also show as a wrong write count in the memory model within a few cycles of the key edge that should have moved it. A wrong captured mode or run flag appears as Q taking the wrong source, as continuous writes after a stop request, or as SAR drifting in same-address run. Each of these is visible on the port registers within one access time. Ignored presses are checked by confirming that A and memory keep the first value after a second press during a long write.

// File: rtl/cm_pkg.sv
package cm_pkg;
   typedef enum logic [1:0] {
      MODE_ADDR  = 2'b00,
      MODE_ALTER = 2'b01,
      MODE_DISP  = 2'b10,
      MODE_NONE  = 2'b11
   } cm_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR_HOLD,
      ST_READ,
      ST_HOLD,
      ST_WRITE
   } cm_state_e;

   typedef struct packed {
      logic ld_sar_sw;
      logic ld_a_sw;
      logic ld_b_mem;
      logic ld_q;
      logic q_from_b;
      logic inc_sar;
   } cm_ctrl_t;
endpackage

// File: rtl/cm_key_sync.sv
module cm_key_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic key_in,
   output logic key_lvl,
   output logic key_rise
);
   logic key_prev;

   generate
      if (STAGES == 0) begin : g_bypass
         assign key_lvl = key_in;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], key_in};
         end
         assign key_lvl = chain[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) key_prev <= 1'b0;
      else     key_prev <= key_lvl;
   end

   assign key_rise = key_lvl & ~key_prev;
endmodule

// File: rtl/cm_sequencer.sv
module cm_sequencer
   import cm_pkg::*;
(
   input  logic     clk,
   input  logic     rst,
   input  logic [1:0] mode_sel,
   input  logic     run_sw,
   input  logic     sweep_sw,
   input  logic     incr_sw,
   input  logic     key_lvl,
   input  logic     key_rise,
   input  logic     mem_done,
   output logic     mem_rd,
   output logic     mem_wr,
   output logic     wsel_b,
   output cm_ctrl_t ctrl
);
   cm_state_e state, nxt;
   cm_mode_e  mode_q;
   logic      run_q, sweep_q, stop_q;
   logic      mode_chg, stop_now;

   assign mode_chg = (cm_mode_e'(mode_sel) != mode_q);
   assign stop_now = stop_q | key_rise | mode_chg;
   assign mem_rd   = (state == ST_READ);
   assign mem_wr   = (state == ST_WRITE);
   assign wsel_b   = (mode_q == MODE_DISP);

   always_comb begin
      ctrl = '0;
      nxt  = state;
      case (state)
         ST_IDLE: begin
            if (key_rise) begin
               case (cm_mode_e'(mode_sel))
                  MODE_ADDR: begin
                     ctrl.ld_sar_sw = 1'b1;
                     ctrl.ld_a_sw   = 1'b1;
                     nxt            = ST_ADDR_HOLD;
                  end
                  MODE_ALTER: begin
                     ctrl.ld_a_sw = 1'b1;
                     nxt          = run_sw ? ST_WRITE : ST_HOLD;
                  end
                  MODE_DISP: nxt = ST_READ;
                  default:   nxt = ST_IDLE;
               endcase
            end
         end
         ST_ADDR_HOLD: begin
            ctrl.ld_a_sw = key_lvl;
            if (!key_lvl) nxt = ST_IDLE;
         end
         ST_READ: begin
            if (mem_done) begin
               ctrl.ld_b_mem = 1'b1;
               nxt           = run_q ? ST_WRITE : ST_HOLD;
            end
         end
         ST_HOLD: begin
            if (!key_lvl) nxt = ST_WRITE;
         end
         ST_WRITE: begin
            if (mem_done) begin
               ctrl.ld_q     = 1'b1;
               ctrl.q_from_b = (mode_q == MODE_DISP);
               ctrl.inc_sar  = run_q ? sweep_q : incr_sw;
               if (run_q && !stop_now)
                  nxt = (mode_q == MODE_DISP) ? ST_READ : ST_WRITE;
               else
                  nxt = ST_IDLE;
            end
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state   <= ST_IDLE;
         mode_q  <= MODE_NONE;
         run_q   <= 1'b0;
         sweep_q <= 1'b0;
         stop_q  <= 1'b0;
      end else begin
         state <= nxt;
         if (state == ST_IDLE && key_rise) begin
            mode_q  <= cm_mode_e'(mode_sel);
            run_q   <= run_sw;
            sweep_q <= sweep_sw;
            stop_q  <= 1'b0;
         end else if (nxt == ST_IDLE) begin
            stop_q <= 1'b0;
         end else if (run_q && (key_rise || mode_chg)) begin
            stop_q <= 1'b1;
         end
      end
   end

   assert_one_strobe_R12: assert property (@(posedge clk) disable iff (rst)
      !(mem_rd && mem_wr));
   assert_rd_held_R12: assert property (@(posedge clk) disable iff (rst)
      (mem_rd && !mem_done) |=> mem_rd);
   assert_wr_held_R12: assert property (@(posedge clk) disable iff (rst)
      (mem_wr && !mem_done) |=> mem_wr);
   assert_idle_after_stop_R9: assert property (@(posedge clk) disable iff (rst)
      (mem_wr && mem_done && stop_q) |=> !mem_rd && !mem_wr);
endmodule

// File: rtl/cm_regs.sv
module cm_regs
   import cm_pkg::*;
#(
   parameter int SW_W   = 16,
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  cm_ctrl_t          ctrl,
   input  logic [SW_W-1:0]   sw,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_rd,
   input  logic              mem_wr,
   input  logic              mem_done,
   output logic [ADDR_W-1:0] sar,
   output logic [DATA_W-1:0] a_reg,
   output logic [DATA_W-1:0] b_reg,
   output logic [DATA_W-1:0] q_reg
);
   localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

   always_ff @(posedge clk) begin
      if (rst) begin
         sar   <= '0;
         a_reg <= '0;
         b_reg <= '0;
         q_reg <= '0;
      end else begin
         if (ctrl.ld_sar_sw)    sar <= sw[ADDR_W-1:0];
         else if (ctrl.inc_sar) sar <= sar + ONE;
         if (ctrl.ld_a_sw)  a_reg <= sw[DATA_W-1:0];
         if (ctrl.ld_b_mem) b_reg <= mem_rdata;
         if (ctrl.ld_q)     q_reg <= ctrl.q_from_b ? b_reg : a_reg;
      end
   end

   assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> (sar == '0 && a_reg == '0 && b_reg == '0 && q_reg == '0));
   assert_addr_held_R12: assert property (@(posedge clk) disable iff (rst)
      ((mem_rd || mem_wr) && !mem_done) |=> $stable(sar));
   assert_q_on_write_R3: assert property (@(posedge clk) disable iff (rst)
      !(mem_wr && mem_done) |=> $stable(q_reg));
   assert_b_on_read_R4: assert property (@(posedge clk) disable iff (rst)
      !(mem_rd && mem_done) |=> $stable(b_reg));
endmodule

// File: rtl/console_mem_access.sv
module console_mem_access
   import cm_pkg::*;
#(
   parameter int SW_W        = 16,
   parameter int ADDR_W      = 10,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [1:0]        mode_sel,
   input  logic [SW_W-1:0]   sw,
   input  logic              start_key,
   input  logic              test_run,
   input  logic              sweep_all,
   input  logic              addr_inc,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_done,
   output logic [ADDR_W-1:0] sar_o,
   output logic [DATA_W-1:0] a_o,
   output logic [DATA_W-1:0] b_o,
   output logic [DATA_W-1:0] q_o
);
   if (DATA_W > SW_W) begin : g_bad_data_w
      $error("DATA_W must not exceed SW_W");
   end
   if (ADDR_W > SW_W) begin : g_bad_addr_w
      $error("ADDR_W must not exceed SW_W");
   end
   if (SYNC_STAGES == 1 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must be 0 or 2 to 4");
   end

   logic     key_lvl, key_rise, wsel_b;
   cm_ctrl_t ctrl;

   cm_key_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .key_in(start_key),
      .key_lvl(key_lvl), .key_rise(key_rise)
   );

   cm_sequencer u_seq (
      .clk(clk), .rst(rst), .mode_sel(mode_sel),
      .run_sw(test_run), .sweep_sw(sweep_all), .incr_sw(addr_inc),
      .key_lvl(key_lvl), .key_rise(key_rise), .mem_done(mem_done),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .wsel_b(wsel_b), .ctrl(ctrl)
   );

   cm_regs #(.SW_W(SW_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst(rst), .ctrl(ctrl), .sw(sw), .mem_rdata(mem_rdata),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_done(mem_done),
      .sar(sar_o), .a_reg(a_o), .b_reg(b_o), .q_reg(q_o)
   );

   assign mem_addr  = sar_o;
   assign mem_wdata = wsel_b ? b_o : a_o;
endmodule

// File: tb/tb_console_mem_access.sv
`timescale 1ns/1ps
module tb_console_mem_access;
   localparam int SW_W = 16, ADDR_W = 10, DATA_W = 8;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [1:0] mode_sel = 2'b11;
   logic [SW_W-1:0] sw = '0;
   logic start_key = 1'b0, test_run = 1'b0, sweep_all = 1'b0, addr_inc = 1'b0;
   logic mem_rd, mem_wr, mem_done;
   logic [ADDR_W-1:0] mem_addr, sar_o;
   logic [DATA_W-1:0] mem_wdata, mem_rdata, a_o, b_o, q_o;

   int checks = 0, fails = 0;
   int rd_cnt = 0, wr_cnt = 0;
   int lat = 2, cnt = 0;
   logic [7:0] mem [0:1023];
   bit finished = 0;

   always #2 clk = ~clk;

   console_mem_access dut (
      .clk(clk), .rst(rst), .mode_sel(mode_sel), .sw(sw), .start_key(start_key),
      .test_run(test_run), .sweep_all(sweep_all), .addr_inc(addr_inc),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_done(mem_done),
      .sar_o(sar_o), .a_o(a_o), .b_o(b_o), .q_o(q_o)
   );

   // memory model: done pulses lat cycles after a strobe is seen
   always @(posedge clk) begin
      if (rst) begin
         mem_done <= 1'b0; cnt <= 0; mem_rdata <= '0;
      end else if (mem_done) begin
         mem_done <= 1'b0; cnt <= 0;
      end else if (mem_rd || mem_wr) begin
         if (cnt >= lat - 1) begin
            mem_done <= 1'b1;
            if (mem_rd) begin mem_rdata <= mem[mem_addr]; rd_cnt <= rd_cnt + 1; end
            else begin mem[mem_addr] <= mem_wdata; wr_cnt <= wr_cnt + 1; end
         end else cnt <= cnt + 1;
      end else cnt <= 0;
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic key(input bit v, input int n);
      @(negedge clk) start_key = v;
      cyc(n);
   endtask

   task automatic set_sar(input logic [SW_W-1:0] v);
      mode_sel = 2'b00; sw = v;
      key(1, 6); key(0, 6);
   endtask

   task automatic t_reset;
      check(sar_o == 0 && a_o == 0 && b_o == 0 && q_o == 0, "R1 regs", {sar_o, a_o}, 0);
      check(!mem_rd && !mem_wr, "R1 strobes", {mem_rd, mem_wr}, 0);
   endtask

   task automatic t_alter_addr;
      int w0 = wr_cnt;
      mode_sel = 2'b00; sw = 16'h1234;
      key(1, 6);
      check(sar_o == 10'h234, "R2 sar load", sar_o, 10'h234);
      check(a_o == 8'h34, "R2 a load", a_o, 8'h34);
      @(negedge clk) sw = 16'h1256;
      cyc(4);
      check(a_o == 8'h56 && sar_o == 10'h234, "R2 a follows", a_o, 8'h56);
      key(0, 8);
      check(wr_cnt == w0 && rd_cnt == 0, "R2 no access", wr_cnt, w0);
   endtask

   task automatic t_alter_store;
      int w0;
      addr_inc = 0;
      mode_sel = 2'b01; sw = 16'h00A5;
      w0 = wr_cnt;
      key(1, 8);
      check(a_o == 8'hA5 && wr_cnt == w0 && q_o == 0, "R3 press", a_o, 8'hA5);
      key(0, 12);
      check(mem[10'h234] == 8'hA5, "R3 mem", mem[10'h234], 8'hA5);
      check(q_o == 8'hA5, "R3 q", q_o, 8'hA5);
      check(wr_cnt == w0 + 1, "R6 one write", wr_cnt - w0, 1);
      check(sar_o == 10'h234, "R5 no incr", sar_o, 10'h234);
   endtask

   task automatic t_display;
      int r0, w0;
      mem[10'h100] = 8'h3C;
      set_sar(16'h0100);
      mode_sel = 2'b10;
      r0 = rd_cnt; w0 = wr_cnt;
      key(1, 10);
      check(b_o == 8'h3C, "R4 b", b_o, 8'h3C);
      check(rd_cnt == r0 + 1 && wr_cnt == w0, "R6 one read", rd_cnt - r0, 1);
      check(q_o == 8'hA5, "R4 q before release", q_o, 8'hA5);
      key(0, 12);
      check(q_o == 8'h3C && mem[10'h100] == 8'h3C, "R4 writeback", q_o, 8'h3C);
      check(wr_cnt == w0 + 1, "R6 one writeback", wr_cnt - w0, 1);
   endtask

   task automatic t_incr;
      addr_inc = 1;
      mode_sel = 2'b01; sw = 16'h005A;
      key(1, 6); key(0, 12);
      check(mem[10'h100] == 8'h5A, "R5 mem", mem[10'h100], 8'h5A);
      check(sar_o == 10'h101, "R5 incr", sar_o, 10'h101);
      addr_inc = 0;
   endtask

   task automatic t_mode_none;
      int w0 = wr_cnt, r0 = rd_cnt;
      mode_sel = 2'b11; sw = 16'hFFFF;
      key(1, 6); key(0, 10);
      check(sar_o == 10'h101 && a_o == 8'h5A && b_o == 8'h3C && q_o == 8'h5A,
            "R11 regs", {sar_o, a_o}, {10'h101, 8'h5A});
      check(wr_cnt == w0 && rd_cnt == r0, "R11 no access", wr_cnt - w0, 0);
   endtask

   task automatic t_busy;
      int w0;
      lat = 10;
      set_sar(16'h0200);
      mode_sel = 2'b01; sw = 16'h0011;
      w0 = wr_cnt;
      key(1, 6);
      key(0, 5);
      sw = 16'h0022;
      key(1, 4);
      key(0, 25);
      check(a_o == 8'h11, "R10 a kept", a_o, 8'h11);
      check(mem[10'h200] == 8'h11 && wr_cnt == w0 + 1, "R10 one write", wr_cnt - w0, 1);
      lat = 2;
   endtask

   task automatic t_run_same;
      int w0, w1;
      mem[10'h051] = 8'h00;
      set_sar(16'h0050);
      mode_sel = 2'b01; sw = 16'h0077; test_run = 1; sweep_all = 0; addr_inc = 1;
      w0 = wr_cnt;
      key(1, 4); key(0, 40);
      check(wr_cnt - w0 >= 3, "R7 repeated", wr_cnt - w0, 3);
      check(sar_o == 10'h050 && mem[10'h051] == 8'h00, "R7 same addr", sar_o, 10'h050);
      key(1, 4); key(0, 20);
      w1 = wr_cnt;
      cyc(15);
      check(wr_cnt == w1 && !mem_wr, "R9 key stop", wr_cnt - w1, 0);
      check(mem[10'h050] == 8'h77 && q_o == 8'h77, "R7 data", q_o, 8'h77);
      addr_inc = 0;
   endtask

   task automatic t_run_sweep;
      int w1;
      mem[10'h3FE] = 0; mem[10'h3FF] = 0; mem[10'h000] = 0;
      test_run = 0;
      set_sar(16'h03FE);
      mode_sel = 2'b01; sw = 16'h0099; test_run = 1; sweep_all = 1;
      key(1, 4); key(0, 30);
      @(negedge clk) mode_sel = 2'b11;
      cyc(20);
      w1 = wr_cnt;
      cyc(15);
      check(wr_cnt == w1 && !mem_wr, "R9 mode stop", wr_cnt - w1, 0);
      check(mem[10'h3FE] == 8'h99 && mem[10'h3FF] == 8'h99 && mem[10'h000] == 8'h99,
            "R8 sweep wrap", mem[10'h000], 8'h99);
      check(sar_o > 10'h000 && sar_o < 10'h3FE, "R8 sar wrapped", sar_o, 1);
      test_run = 0; sweep_all = 0;
   endtask

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
      cyc(5);
      check(sar_o == 0 && q_o == 0, "R1 during reset", sar_o, 0);
      @(negedge clk) rst = 1'b0;
      cyc(2);
      t_reset();
      t_alter_addr();
      t_alter_store();
      t_display();
      t_incr();
      t_mode_none();
      t_busy();
      t_run_same();
      t_run_sweep();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
      end
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
      end
      $finish;
   end
endmodule